// File: doc/BRIEF.md
# Decode-Stage Next-PC Resolver

This block picks the address the fetch stage uses next in a five-stage pipeline that resolves control transfers in the decode stage and has one delay slot. The decode stage supplies its instruction word, the incremented address of that instruction, and the two comparison operands. Those operands already carry any forwarded values. The block builds a jump target and a branch target from that instruction. It compares the operands for an equality branch. It then chooses among the jump target, the branch target and the sequential successor of the fetch address, and holds that choice in the fetch program counter register.

The block flushes nothing. The instruction fetched while a branch or jump sits in decode is the delay-slot instruction, and it always runs. The redirected address is loaded on the clock edge that follows, so fetch goes on from the target with no lost cycle. The comparator only sees values that are read or forwarded from the memory stage. Software must therefore place one independent instruction between an ALU result and a branch that compares it. The block makes no check of that rule.

Top module: `id_npc_resolver`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, the fetch address `pc` equals 0.
- R2: When the decode opcode (instruction bits 31..26) is neither 000100 nor 000010, `next_pc` equals `pc + 4`, `redirect` is low, and `pc` goes up by 4 on each clock edge.
- R3: `jump_target` is always bits 31..28 of `id_pc_plus4`, followed by instruction bits 25..0, followed by two zero bits. A jump therefore stays inside the 256 MB region of its incremented address.
- R4: `branch_target` is always `id_pc_plus4` plus the sign-extended instruction bits 15..0 shifted left by two, taken modulo 2^32. Negative offsets and wrap below address 0 are included.
- R5: `branch_taken` is high exactly when the opcode is 000100 and `cmp_a` equals `cmp_b`. Any other opcode gives a low `branch_taken`, even when the operands match.
- R6: Opcode 000010 selects `jump_target` as `next_pc`, whatever the operands are. The order of choice is jump first, then taken branch, then sequential.
- R7: A taken branch selects `branch_target`. A not-taken branch (opcode 000100 with unequal operands) selects `pc + 4`.
- R8: `redirect` is high exactly when `next_pc` comes from a jump or a taken branch. `pc` takes the value of `next_pc` on every clock edge out of reset. A redirect therefore reaches fetch one edge after the control instruction is in decode. The delay-slot instruction fetched at the old address is kept, and a non-control instruction in the delay slot leads to fetch at target + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_instr | input | 32 | Instruction word in the decode stage |
| id_pc_plus4 | input | 32 | Incremented address of the decode-stage instruction |
| cmp_a | input | 32 | First comparison operand, already forwarded |
| cmp_b | input | 32 | Second comparison operand, already forwarded |
| jump_target | output | 32 | Region-relative jump address |
| branch_target | output | 32 | PC-relative branch address |
| branch_taken | output | 1 | Equality branch is taken |
| redirect | output | 1 | Next address is not sequential |
| next_pc | output | 32 | Address loaded into the fetch register on the next edge |
| pc | output | 32 | Fetch program counter register |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 6-bit opcode, 16-bit immediate, 26-bit jump field and reset address 0. It uses the XOR-tree comparator variant. With these values, single-bit operand differences, a branch offset that wraps below zero, and a 26-bit field of all ones next to a 256 MB boundary can all be driven directly. This exercises the carry from the branch adder and the splice into the upper address bits at their extremes.

// File: rtl/npc_pkg.sv
package npc_pkg;

   // Source of the next fetch address
   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_JUMP   = 2'd2
   } npc_src_e;

   localparam int unsigned NPC_DEF_XLEN = 32;
   localparam int unsigned NPC_DEF_OPW  = 6;
   localparam int unsigned NPC_DEF_IMMW = 16;
   localparam int unsigned NPC_DEF_JFW  = 26;

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned IMMW = 16,
   parameter int unsigned JFW  = 26
) (
   input  logic [XLEN-1:0] pc_plus4,
   input  logic [JFW-1:0]  jfield,
   output logic [XLEN-1:0] jump_target,
   output logic [XLEN-1:0] branch_target
);
   localparam int unsigned REGION_W = XLEN - JFW - 2;
   localparam int unsigned EXT_W    = XLEN - IMMW;

   logic [IMMW-1:0] imm;
   logic [XLEN-1:0] imm_sext;
   logic [XLEN-1:0] byte_off;

   assign imm      = jfield[IMMW-1:0];
   assign imm_sext = {{EXT_W{imm[IMMW-1]}}, imm};
   assign byte_off = {imm_sext[XLEN-3:0], 2'b00};

   // Region-relative jump: keep the upper bits of the incremented address
   assign jump_target   = {pc_plus4[XLEN-1 -: REGION_W], jfield, 2'b00};
   // PC-relative branch, modulo 2^XLEN
   assign branch_target = pc_plus4 + byte_off;

   // Word alignment of both targets holds when the incremented address is aligned
   always_comb begin
      if (pc_plus4[1:0] == 2'b00) begin
         a_r4_branch_aligned: assert (branch_target[1:0] == 2'b00 || $isunknown(pc_plus4))
            else $error("branch target not word aligned");
      end
   end

endmodule

// File: rtl/npc_branch_cmp.sv
module npc_branch_cmp #(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned OPW          = 6,
   parameter logic [5:0]  OP_BEQ       = 6'b000100,
   parameter bit          CMP_XOR_TREE = 1'b1
) (
   input  logic [OPW-1:0]  opcode,
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   output logic            taken
);
   localparam logic [OPW-1:0] BEQ_CODE = OPW'(OP_BEQ);

   logic equal;
   logic is_beq;

   generate
      if (CMP_XOR_TREE) begin : g_xor_tree
         logic [XLEN-1:0] diff;
         assign diff  = op_a ^ op_b;
         assign equal = ~|diff;
      end else begin : g_direct
         assign equal = (op_a == op_b);
      end
   endgenerate

   assign is_beq = (opcode == BEQ_CODE);
   assign taken  = is_beq & equal;

endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned OPW  = 6,
   parameter logic [5:0]  OP_J = 6'b000010
) (
   input  logic [OPW-1:0]  opcode,
   input  logic            taken,
   input  logic [XLEN-1:0] seq_pc,
   input  logic [XLEN-1:0] jump_target,
   input  logic [XLEN-1:0] branch_target,
   output logic [XLEN-1:0] next_pc,
   output npc_src_e        src
);
   localparam logic [OPW-1:0] J_CODE = OPW'(OP_J);

   // Priority: jump, then taken branch, then sequential
   always_comb begin
      if (opcode == J_CODE)  src = NPC_JUMP;
      else if (taken)        src = NPC_BRANCH;
      else                   src = NPC_SEQ;
   end

   always_comb begin
      unique case (src)
         NPC_JUMP:   next_pc = jump_target;
         NPC_BRANCH: next_pc = branch_target;
         default:    next_pc = seq_pc;
      endcase
   end

endmodule

// File: rtl/id_npc_resolver.sv
module id_npc_resolver
   import npc_pkg::*;
#(
   parameter int unsigned   XLEN         = 32,
   parameter int unsigned   INSN_W       = 32,
   parameter int unsigned   OPW          = 6,
   parameter int unsigned   IMMW         = 16,
   parameter int unsigned   JFW          = 26,
   parameter logic [5:0]    OP_BEQ       = 6'b000100,
   parameter logic [5:0]    OP_J         = 6'b000010,
   parameter logic [31:0]   RESET_PC     = 32'h0000_0000,
   parameter bit            CMP_XOR_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] id_instr,
   input  logic [XLEN-1:0]   id_pc_plus4,
   input  logic [XLEN-1:0]   cmp_a,
   input  logic [XLEN-1:0]   cmp_b,
   output logic [XLEN-1:0]   jump_target,
   output logic [XLEN-1:0]   branch_target,
   output logic              branch_taken,
   output logic              redirect,
   output logic [XLEN-1:0]   next_pc,
   output logic [XLEN-1:0]   pc
);
   localparam logic [XLEN-1:0] STEP     = XLEN'(4);
   localparam logic [XLEN-1:0] PC_INIT  = XLEN'(RESET_PC);
   localparam logic [OPW-1:0]  J_CODE   = OPW'(OP_J);
   localparam logic [OPW-1:0]  BEQ_CODE = OPW'(OP_BEQ);

   // Elaboration-time parameter checks
   generate
      if (INSN_W != OPW + JFW) begin : g_bad_insn
         $error("INSN_W must equal OPW + JFW");
      end
      if (JFW + 2 >= XLEN) begin : g_bad_jfw
         $error("jump field plus alignment must leave region bits");
      end
      if (IMMW > JFW || IMMW + 2 > XLEN) begin : g_bad_imm
         $error("immediate width out of range");
      end
      if (OPW > 6) begin : g_bad_opw
         $error("opcode codes are 6 bits wide");
      end
   endgenerate

   logic [OPW-1:0]  opcode;
   logic [JFW-1:0]  jfield;
   logic [XLEN-1:0] seq_pc;
   npc_src_e        src;

   assign opcode = id_instr[INSN_W-1 -: OPW];
   assign jfield = id_instr[JFW-1:0];
   assign seq_pc = pc + STEP;

   npc_target_gen #(
      .XLEN (XLEN),
      .IMMW (IMMW),
      .JFW  (JFW)
   ) u_targets (
      .pc_plus4      (id_pc_plus4),
      .jfield        (jfield),
      .jump_target   (jump_target),
      .branch_target (branch_target)
   );

   npc_branch_cmp #(
      .XLEN         (XLEN),
      .OPW          (OPW),
      .OP_BEQ       (OP_BEQ),
      .CMP_XOR_TREE (CMP_XOR_TREE)
   ) u_cmp (
      .opcode (opcode),
      .op_a   (cmp_a),
      .op_b   (cmp_b),
      .taken  (branch_taken)
   );

   npc_select #(
      .XLEN (XLEN),
      .OPW  (OPW),
      .OP_J (OP_J)
   ) u_sel (
      .opcode        (opcode),
      .taken         (branch_taken),
      .seq_pc        (seq_pc),
      .jump_target   (jump_target),
      .branch_target (branch_target),
      .next_pc       (next_pc),
      .src           (src)
   );

   assign redirect = (src != NPC_SEQ);

   // Fetch program counter; no flush, the delay slot is already fetched
   always_ff @(posedge clk) begin
      if (!rst_n) pc <= PC_INIT;
      else        pc <= next_pc;
   end

   // R5: a taken flag needs the branch opcode and equal operands
   a_r5_taken_needs_equal: assert property (@(posedge clk) disable iff (!rst_n)
      branch_taken |-> (opcode == BEQ_CODE && cmp_a == cmp_b))
      else $error("taken without equal operands");

   // R6: jump wins over any branch outcome
   a_r6_jump_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == J_CODE) |-> (next_pc == jump_target && redirect))
      else $error("jump not selected");

   // R6 / R8: jump target reaches the fetch register on the next edge
   a_r8_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == J_CODE) |=> (pc == $past(jump_target)))
      else $error("jump target not loaded");

   // R7: a taken branch lands on the branch target
   a_r7_branch_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (branch_taken && opcode != J_CODE) |=> (pc == $past(branch_target)))
      else $error("branch target not loaded");

   // R2: without redirect fetch advances by one word
   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> (pc == $past(pc) + STEP))
      else $error("sequential step wrong");

endmodule

// File: tb/test_id_npc_resolver.sv
`timescale 1ns/1ps
module test_id_npc_resolver;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] id_instr, id_pc_plus4, cmp_a, cmp_b;
   logic [31:0] jump_target, branch_target, next_pc, pc;
   logic        branch_taken, redirect;

   int unsigned checks = 0;
   int unsigned errors = 0;
   logic [31:0] model_pc;

   always #2.5 clk = ~clk;

   id_npc_resolver i_id_npc_resolver (
      .clk           (clk),
      .rst_n         (rst_n),
      .id_instr      (id_instr),
      .id_pc_plus4   (id_pc_plus4),
      .cmp_a         (cmp_a),
      .cmp_b         (cmp_b),
      .jump_target   (jump_target),
      .branch_target (branch_target),
      .branch_taken  (branch_taken),
      .redirect      (redirect),
      .next_pc       (next_pc),
      .pc            (pc)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_j(input logic [25:0] f);
      return {6'b000010, f};
   endfunction

   function automatic logic [31:0] mk_beq(input logic [15:0] imm);
      return {6'b000100, 5'd3, 5'd4, imm};
   endfunction

   // Expected branch target from integer arithmetic
   function automatic logic [31:0] exp_br(input logic [31:0] p4, input logic [15:0] imm);
      longint off;
      off = longint'($signed(imm)) * 4;
      return 32'(longint'(p4) + off);
   endfunction

   // Drive at negedge, check combinational result, then check the register
   task automatic step(input string tag, input logic [31:0] exp_next, input logic exp_redir);
      #1;
      chk({tag, " next_pc"}, next_pc, exp_next);
      chk({tag, " redirect"}, {31'd0, redirect}, {31'd0, exp_redir});
      @(posedge clk); #1;
      chk({tag, " pc"}, pc, exp_next);
      model_pc = exp_next;
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; id_instr = '0; id_pc_plus4 = '0; cmp_a = '0; cmp_b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 pc in reset", pc, 32'h0);
      rst_n = 1'b1;
      #1 chk("R1 pc after release", pc, 32'h0);
      model_pc = 32'h0;
      step("R2 seq 1", 32'h4, 1'b0);
      step("R2 seq 2", 32'h8, 1'b0);
   endtask

   task automatic t_jump_boundary;
      // field all ones just below a 256 MB boundary
      id_pc_plus4 = 32'h0FFF_FFFC; id_instr = mk_j(26'h3FF_FFFF);
      cmp_a = 32'h1; cmp_b = 32'h2;
      #1 chk("R3 jump top of region", jump_target, 32'h0FFF_FFFC);
      step("R6 jump top", 32'h0FFF_FFFC, 1'b1);
      // delay slot: non-control, fetch continues at target + 4
      id_instr = 32'h0022_1820; id_pc_plus4 = 32'h1234_5678;
      step("R8 delay slot seq", 32'h1000_0000, 1'b0);
      // just past the boundary, upper nibble 1
      id_pc_plus4 = 32'h1000_0000; id_instr = mk_j(26'h000_0000);
      #1 chk("R3 jump new region", jump_target, 32'h1000_0000);
      step("R6 jump new region", 32'h1000_0000, 1'b1);
      // region kept even when the incremented address is near the end of it
      id_pc_plus4 = 32'hFFFF_FFF0; id_instr = mk_j(26'h000_0040);
      #1 chk("R3 jump high region", jump_target, 32'hF000_0100);
   endtask

   task automatic t_beq_taken;
      id_pc_plus4 = 32'h0000_0430; id_instr = mk_beq(16'hFF9C);
      cmp_a = 32'hDEAD_BEEF; cmp_b = 32'hDEAD_BEEF;
      #1;
      chk("R4 branch target -100", branch_target, exp_br(32'h0000_0430, 16'hFF9C));
      chk("R5 taken on equal", {31'd0, branch_taken}, 32'd1);
      step("R7 taken lands", exp_br(32'h0000_0430, 16'hFF9C), 1'b1);
      id_instr = 32'h0;
      step("R8 after branch slot", exp_br(32'h0000_0430, 16'hFF9C) + 32'd4, 1'b0);
   endtask

   task automatic t_beq_not_taken;
      logic [31:0] exp_seq;
      id_pc_plus4 = 32'h0000_2000; id_instr = mk_beq(16'h8000);
      cmp_a = 32'h8000_0000; cmp_b = 32'h0000_0000;
      #1;
      chk("R4 most negative offset", branch_target, exp_br(32'h0000_2000, 16'h8000));
      chk("R5 not taken top bit", {31'd0, branch_taken}, 32'd0);
      exp_seq = model_pc + 32'd4;
      step("R7 not taken seq", exp_seq, 1'b0);
      cmp_a = 32'h0000_0001; cmp_b = 32'h0000_0000;
      #1 chk("R5 not taken low bit", {31'd0, branch_taken}, 32'd0);
   endtask

   task automatic t_beq_wrap;
      id_pc_plus4 = 32'h0000_0004; id_instr = mk_beq(16'hFFFE);
      cmp_a = 32'h5; cmp_b = 32'h5;
      #1 chk("R4 wrap below zero", branch_target, 32'hFFFF_FFFC);
      step("R7 taken wrap", 32'hFFFF_FFFC, 1'b1);
   endtask

   task automatic t_priority_and_other;
      logic [31:0] exp_seq;
      // jump with equal operands and branch-like low bits
      id_pc_plus4 = 32'h2000_0010; id_instr = mk_j(26'h000_FFFF);
      cmp_a = 32'h7; cmp_b = 32'h7;
      #1 chk("R5 jump not a branch", {31'd0, branch_taken}, 32'd0);
      step("R6 jump with equal operands", 32'h2003_FFFC, 1'b1);
      // unrelated opcode 000101 with equal operands stays sequential
      id_instr = {6'b000101, 5'd3, 5'd4, 16'hFFF0};
      #1 chk("R5 other opcode", {31'd0, branch_taken}, 32'd0);
      exp_seq = model_pc + 32'd4;
      step("R2 other opcode seq", exp_seq, 1'b0);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_jump_boundary();
      t_beq_taken();
      t_beq_not_taken();
      t_beq_wrap();
      t_priority_and_other();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule